// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. It samples the clock and data lines through a synchronizer on the system clock and finds Start, repeated Start and Stop conditions. It then decodes a device select byte against a fixed type code and three strap inputs. When the byte matches, the block acknowledges it and takes a two-byte word address. It writes single bytes or whole pages into a small internal array. It serves reads at the current address, at a random address (a dummy write followed by a repeated Start) and sequential reads that go on for as long as the master keeps acknowledging.

Written bytes first go to a page-sized staging buffer and reach the array only when a Stop arrives. A repeated Start drops any staged bytes. A write-control input blocks data writes. The data line is open drain: the block only ever pulls it low through `sda_oe`, and `sda_o` stays low.

Top module: `twi_eeprom_slave`

## Requirements
- R1: SDA falling while SCL is high is a Start. From any state, including the middle of a byte, a Start begins reception of a new select byte. SDA rising while SCL is high is a Stop. After a Stop the block releases SDA and ignores SCL until the next Start.
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `chip_en[2:0]` (bit 3 against `chip_en[2]`), and bit 0 is the direction (1 = read, 0 = write). On a match the block holds SDA low for the whole 9th clock.
- R3: On a mismatch the block does not acknowledge. It also acknowledges no later byte and drives nothing until the next Start.
- R4: After a write select, the high address byte and then the low address byte are received, and each is acknowledged. Only the low log2(MEM_BYTES) bits of the 16-bit address are used.
- R5: While `wr_ctl` is low, every write data byte is acknowledged and staged. Staged bytes are written to the array at Stop and dropped at a repeated Start.
- R6: Within one write transfer, the address offset wraps inside its PAGE_BYTES-aligned page, and the page bits do not change.
- R7: While `wr_ctl` is high, write data bytes are not acknowledged, not stored, and do not move the address pointer.
- R8: A read select directly after Start returns the byte at the internal pointer, MSB first. The pointer moves up by one after each byte that is read or accepted for writing.
- R9: A write select, two address bytes, a repeated Start and a read select return data starting at the given address.
- R10: A sequential read returns successive bytes while the master acknowledges, wrapping from the last address to 0. After a master NACK the block releases SDA.
- R11: The block changes its SDA drive only while SCL is low.
- R12: After reset SDA is released and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the bus |
| sda_o | output | 1 | Data output level, always low (open drain) |
| sda_oe | output | 1 | High pulls SDA low |
| chip_en | input | 3 | Strap levels compared with select bits 3..1 |
| wr_ctl | input | 1 | High blocks data writes |

## Verification
On every cycle, the assertions check that SDA drive changes only while SCL is low. They also check that Start and Stop put the controller in the right state, that a select acknowledge happens only for a matching byte, that `wr_ctl` suppresses the data acknowledge, that the page bits hold during a write, and that a commit empties the staging buffer. Only the bench scenarios can show the data path itself. That covers contents read back after page writes that wrap, the pointer carried between transactions, the wrap across the end of the array, staged bytes dropped at a repeated Start, and the full sweep of type codes and strap values.

// File: rtl/eeprom_twi_pkg.sv
package eeprom_twi_pkg;

   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_WDATA,
      ST_RDATA
   } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $error("twi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] lines_in;
   logic [1:0] lines_s;
   logic [1:0] lines_q;

   assign lines_in = {sda_i, scl_i};

   for (genvar k = 0; k < 2; k++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe <= '1;
         end else begin
            pipe <= {pipe[STAGES-2:0], lines_in[k]};
         end
      end
      assign lines_s[k] = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= 2'b11;
      end else begin
         lines_q <= lines_s;
      end
   end

   assign scl_s     = lines_s[0];
   assign sda_s     = lines_s[1];
   assign scl_rise  = lines_s[0] & ~lines_q[0];
   assign scl_fall  = ~lines_s[0] & lines_q[0];
   assign start_det = lines_s[0] & lines_q[0] & lines_q[1] & ~lines_s[1];
   assign stop_det  = lines_s[0] & lines_q[0] & ~lines_q[1] & lines_s[1];

endmodule

// File: rtl/twi_page_mem.sv
module twi_page_mem #(
   parameter int MEM_BYTES  = 256,
   parameter int PAGE_BYTES = 32,
   localparam int ADDR_W    = $clog2(MEM_BYTES),
   localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data,
   input  logic                     bw_en,
   input  logic [PAGE_W-1:0]        bw_off,
   input  logic [7:0]               bw_data,
   input  logic                     buf_clr,
   input  logic                     commit,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page
);

   logic [7:0]              mem [MEM_BYTES];
   logic [PAGE_BYTES*8-1:0] data_vec;
   logic [PAGE_BYTES-1:0]   vld_vec;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [7:0] slot_data;
      logic       slot_vld;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_data <= '0;
            slot_vld  <= 1'b0;
         end else if (buf_clr || commit) begin
            slot_vld  <= 1'b0;
         end else if (bw_en && (bw_off == PAGE_W'(g))) begin
            slot_data <= bw_data;
            slot_vld  <= 1'b1;
         end
      end
      assign data_vec[g*8 +: 8] = slot_data;
      assign vld_vec[g]         = slot_vld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (vld_vec[i]) mem[{commit_page, PAGE_W'(i)}] <= data_vec[i*8 +: 8];
         end
      end
   end

   assign rd_data = mem[rd_addr];

   // R5: a commit or a drop leaves no staged byte behind
   assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit || buf_clr) |=> (vld_vec == '0));

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import eeprom_twi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_s,
   input  logic                     sda_s,
   input  logic                     scl_rise,
   input  logic                     scl_fall,
   input  logic                     start_det,
   input  logic                     stop_det,
   input  logic [2:0]               chip_en,
   input  logic                     wr_ctl,
   input  logic [7:0]               rd_data,
   output logic [ADDR_W-1:0]        rd_addr,
   output logic                     bw_en,
   output logic [PAGE_W-1:0]        bw_off,
   output logic [7:0]               bw_data,
   output logic                     buf_clr,
   output logic                     commit,
   output logic [ADDR_W-PAGE_W-1:0] commit_page,
   output logic                     sda_oe
);

   twi_state_e        state;
   logic [3:0]        bitcnt;
   logic              in_ack;
   logic              m_ack;
   logic              rw_q;
   logic [7:0]        shreg;
   logic [7:0]        tx;
   logic [7:0]        addr_hi;
   logic [ADDR_W-1:0] ptr;
   logic              dev_match;
   logic              byte_done;
   logic [15:0]       full_addr;

   assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_en);
   assign byte_done = scl_fall && !in_ack && (bitcnt == 4'd8);
   assign full_addr = {addr_hi, shreg};

   assign rd_addr     = ptr;
   assign bw_en       = byte_done && (state == ST_WDATA) && !wr_ctl;
   assign bw_off      = ptr[PAGE_W-1:0];
   assign bw_data     = shreg;
   assign buf_clr     = start_det;
   assign commit      = stop_det;
   assign commit_page = ptr[ADDR_W-1:PAGE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         in_ack  <= 1'b0;
         m_ack   <= 1'b0;
         rw_q    <= 1'b0;
         shreg   <= '0;
         tx      <= '0;
         addr_hi <= '0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_DEVSEL;
         bitcnt <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (in_ack) begin
               m_ack <= ~sda_s;
            end else if (!bitcnt[3]) begin
               shreg  <= {shreg[6:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end
         end else if (scl_fall) begin
            if (in_ack) begin
               in_ack <= 1'b0;
               bitcnt <= '0;
               sda_oe <= 1'b0;
               unique case (state)
                  ST_DEVSEL: begin
                     if (rw_q) begin
                        state  <= ST_RDATA;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 1'b1;
                     end else begin
                        state <= ST_ADDR_HI;
                     end
                  end
                  ST_ADDR_HI: state <= ST_ADDR_LO;
                  ST_ADDR_LO: state <= ST_WDATA;
                  ST_WDATA:   state <= ST_WDATA;
                  ST_RDATA: begin
                     if (m_ack) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
                  default: state <= ST_IDLE;
               endcase
            end else if (bitcnt == 4'd8) begin
               in_ack <= 1'b1;
               sda_oe <= 1'b0;
               unique case (state)
                  ST_DEVSEL: begin
                     if (dev_match) begin
                        rw_q   <= shreg[0];
                        sda_oe <= 1'b1;
                     end else begin
                        state  <= ST_IDLE;
                        in_ack <= 1'b0;
                     end
                  end
                  ST_ADDR_HI: begin
                     addr_hi <= shreg;
                     sda_oe  <= 1'b1;
                  end
                  ST_ADDR_LO: begin
                     ptr    <= full_addr[ADDR_W-1:0];
                     sda_oe <= 1'b1;
                  end
                  ST_WDATA: begin
                     if (!wr_ctl) begin
                        sda_oe <= 1'b1;
                        ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                     end
                  end
                  ST_RDATA: sda_oe <= 1'b0;
                  default:  state  <= ST_IDLE;
               endcase
            end else if (state == ST_RDATA) begin
               sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
            end
         end
      end
   end

   // R11: drive changes only during SCL low
   assert_sda_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R1: Stop releases the bus and parks the controller
   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE) && !sda_oe);

   // R1: Start always restarts select reception
   assert_start_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEVSEL) && (bitcnt == 4'd0));

   // R3: a deselected device never drives
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R2: select acknowledge only for a matching byte
   assert_select_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_DEVSEL) && in_ack && sda_oe) |-> dev_match);

   // R7: blocked data bytes are not acknowledged
   assert_wc_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (state == ST_WDATA) && wr_ctl) |=> !sda_oe);

   // R6: page bits hold while writing
   assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_WDATA) && ($past(state) == ST_WDATA))
         |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int MEM_BYTES   = 256,
   parameter int PAGE_BYTES  = 32,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(MEM_BYTES),
   localparam int PAGE_W     = $clog2(PAGE_BYTES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_o,
   output logic       sda_oe,
   input  logic [2:0] chip_en,
   input  logic       wr_ctl
);

   generate
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES > 65536) begin : g_bad_mem
         initial $error("twi_eeprom_slave: MEM_BYTES must be a power of two up to 65536");
      end
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2) begin : g_bad_page
         initial $error("twi_eeprom_slave: PAGE_BYTES must be a power of two of at least 2");
      end
      if (PAGE_BYTES >= MEM_BYTES) begin : g_bad_ratio
         initial $error("twi_eeprom_slave: PAGE_BYTES must be below MEM_BYTES");
      end
   endgenerate

   logic                     scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0]        rd_addr;
   logic [7:0]               rd_data;
   logic                     bw_en, buf_clr, commit;
   logic [PAGE_W-1:0]        bw_off;
   logic [7:0]               bw_data;
   logic [ADDR_W-PAGE_W-1:0] commit_page;

   assign sda_o = 1'b0;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twi_slave_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s       (scl_s),
      .sda_s       (sda_s),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .chip_en     (chip_en),
      .wr_ctl      (wr_ctl),
      .rd_data     (rd_data),
      .rd_addr     (rd_addr),
      .bw_en       (bw_en),
      .bw_off      (bw_off),
      .bw_data     (bw_data),
      .buf_clr     (buf_clr),
      .commit      (commit),
      .commit_page (commit_page),
      .sda_oe      (sda_oe)
   );

   twi_page_mem #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .bw_en       (bw_en),
      .bw_off      (bw_off),
      .bw_data     (bw_data),
      .buf_clr     (buf_clr),
      .commit      (commit),
      .commit_page (commit_page)
   );

endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;

   localparam int MEM = 256;
   localparam int PG  = 32;
   localparam int Q   = 6;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl_drv;
   logic       m_sda;
   logic [2:0] chip_en;
   logic       wr_ctl;
   logic       sda_o;
   logic       sda_oe;
   wire        sda_line = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   twi_eeprom_slave uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_drv),
      .sda_i   (sda_line),
      .sda_o   (sda_o),
      .sda_oe  (sda_oe),
      .chip_en (chip_en),
      .wr_ctl  (wr_ctl)
   );

   int         nchk = 0;
   int         nfail = 0;
   bit         done = 0;
   int         r11_bad = 0;
   logic       oe_prev = 1'b0;
   logic [7:0] model [MEM];
   int         mptr = 0;
   logic [2:0] strap = 3'd5;

   // R11 monitor: the drive must not move while the master holds SCL high
   always @(negedge clk) begin
      if (rst_n === 1'b1 && scl_drv === 1'b1 && sda_oe !== oe_prev) r11_bad++;
      oe_prev = sda_oe;
   end

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      scl_drv = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      scl_drv = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      scl_drv = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_bit(bit b);
      m_sda = b; tick(Q);
      scl_drv = 1'b1; tick(Q);
      scl_drv = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output bit b);
      m_sda = 1'b1; tick(Q);
      scl_drv = 1'b1; tick(Q/2);
      b = sda_line; tick(Q/2);
      scl_drv = 1'b0; tick(Q);
   endtask

   task automatic send_byte(logic [7:0] v, output bit acked);
      bit b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic recv_byte(bit mack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(!mack);
   endtask

   function automatic logic [7:0] dev(bit rw);
      return {4'b1010, strap, rw};
   endfunction

   task automatic write_tx(int hi, int lo, int n, int seed);
      bit a;
      int off, base;
      logic [7:0] d;
      bus_start();
      send_byte(dev(0), a); chk("R2 write select ack", a, 1);
      send_byte(8'(hi), a); chk("R4 high address ack", a, 1);
      send_byte(8'(lo), a); chk("R4 low address ack", a, 1);
      off  = lo % PG;
      base = lo - off;
      for (int i = 0; i < n; i++) begin
         d = 8'((seed + i * 7) & 255);
         send_byte(d, a);
         if (wr_ctl) chk("R7 blocked data not acked", a, 0);
         else begin
            chk("R5 data ack", a, 1);
            model[base + ((off + i) % PG)] = d;
         end
      end
      bus_stop();
      mptr = wr_ctl ? lo : base + ((off + n) % PG);
   endtask

   task automatic rand_read(int hi, int lo, int n, string tag);
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte(dev(0), a); chk("R9 dummy write select ack", a, 1);
      send_byte(8'(hi), a); chk("R4 high address ack", a, 1);
      send_byte(8'(lo), a); chk("R4 low address ack", a, 1);
      bus_start();
      send_byte(dev(1), a); chk("R9 read select ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk(tag, int'(d), int'(model[(lo + i) % MEM]));
      end
      bus_stop();
      mptr = (lo + n) % MEM;
   endtask

   task automatic cur_read(int n, string tag);
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte(dev(1), a); chk("R8 current read select ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk(tag, int'(d), int'(model[(mptr + i) % MEM]));
      end
      bus_stop();
      mptr = (mptr + n) % MEM;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] d;
      for (int i = 0; i < MEM; i++) model[i] = 8'h00;
      rst_n   = 1'b0;
      scl_drv = 1'b1;
      m_sda   = 1'b1;
      chip_en = strap;
      wr_ctl  = 1'b0;
      tick(5);
      chk("R12 released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      tick(5);
      chk("R12 released after reset", int'(sda_oe), 0);
      cur_read(1, "R12 array zero after reset");

      // R2/R3 sweep over type codes with matching straps
      for (int t = 0; t < 16; t++) begin
         bus_start();
         send_byte({4'(t), strap, 1'b0}, a);
         chk("R2 type code decode", a, (t == 10) ? 1 : 0);
         if (t != 10) begin
            send_byte(dev(0), a);
            chk("R3 silent after mismatch", a, 0);
         end
         bus_stop();
      end
      // R2/R3 sweep over strap codes
      for (int c = 0; c < 8; c++) begin
         bus_start();
         send_byte({4'b1010, 3'(c), 1'b0}, a);
         chk("R2 strap decode", a, (c == int'(strap)) ? 1 : 0);
         if (c != int'(strap)) begin
            send_byte(dev(0), a);
            chk("R3 silent after mismatch", a, 0);
         end
         bus_stop();
      end

      // R6: fill every page starting at offset 5, wrapping inside the page
      for (int p = 0; p < MEM / PG; p++) write_tx(0, p * PG + 5, PG, p * 31 + 1);
      cur_read(1, "R8 pointer after wrapped page write");
      rand_read(0, 0, MEM, "R10 sequential read of whole array");
      rand_read(0, 8'hFD, 5, "R10 sequential wrap past last address");
      cur_read(3, "R8 current read continues");

      // R4: high address bits beyond the array are ignored
      write_tx(8'h7E, 8'h11, 1, 8'h3C);
      rand_read(8'hC3, 8'h11, 1, "R4 upper address bits ignored");

      // R5: single byte write then current read from next address
      write_tx(0, 8'h22, 1, 8'h5A);
      cur_read(1, "R8 pointer after byte write");

      // R7: write control blocks data
      wr_ctl = 1'b1;
      write_tx(0, 8'h30, 2, 8'hEE);
      wr_ctl = 1'b0;
      cur_read(1, "R7 array and pointer unchanged");

      // R1/R5: staged byte dropped at repeated Start
      bus_start();
      send_byte(dev(0), a); chk("R5 select ack", a, 1);
      send_byte(8'h00, a);  chk("R4 high address ack", a, 1);
      send_byte(8'h50, a);  chk("R4 low address ack", a, 1);
      send_byte(8'h99, a);  chk("R5 staged byte ack", a, 1);
      bus_start();
      send_byte(dev(1), a); chk("R1 restart select ack", a, 1);
      recv_byte(0, d);
      chk("R8 pointer advanced by staged byte", int'(d), int'(model[8'h51]));
      bus_stop();
      rand_read(0, 8'h50, 1, "R5 dropped byte not written");

      // R1: Start in mid-byte restarts select reception
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte(dev(0), a); chk("R1 start mid byte resync", a, 1);
      bus_stop();

      // R10: NACK releases the bus
      bus_start();
      send_byte(dev(1), a); chk("R10 read select ack", a, 1);
      recv_byte(0, d);
      tick(Q);
      chk("R10 released after nack", int'(sda_oe), 0);
      send_bit(1'b1);
      chk("R10 still released", int'(sda_line), 1);
      bus_stop();

      chk("R11 drive changed only with SCL low", r11_bad, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule